// File: doc/BRIEF.md
# Word Refresh Sequencer with Host Arbitration

This block fronts a word-organised storage array whose words must be rewritten periodically to keep their contents. One shared sequencer walks the whole array in ascending address order. At each address it spends one array cycle reading the word into a holding register. It spends a second array cycle writing the same word back, then moves to the next address. After the last address it wraps to zero. The array has a single port. The host owns it whenever it presents a request, and the sequencer only uses cycles in which the host is not accepted.

The sequencer has a time budget: a full pass over the array must finish within `REFRESH_PERIOD` cycles. In every cycle it compares the elapsed time of the current pass with the array cycles the pass still needs. When the two together reach the budget, the block raises an urgency flag and withholds host ready, so the refresh advances on every cycle until the pass wraps. A host write that lands on the word held between the refresh read and its write-back cancels that write-back, so the host data survives. The host side is a valid/ready port, and read data arrives one cycle after acceptance. The parameters must satisfy `REFRESH_PERIOD > 2 * 2**ADDR_W`.

Top module: `refresh_engine`

## Requirements
- R1: While reset is asserted, and during the two cycles the internal reset takes to release after `rst_n` rises, `host_ready`, `host_rvalid`, `rf_urgent` and `sweep_done` are all 0.
- R2: A host read is accepted in a cycle with `host_valid` and `host_ready` both 1 and `host_we` 0. In the next cycle `host_rvalid` is 1 and `host_rdata` holds the word most recently written to that address. An accepted write (`host_we` 1) gives `host_rvalid` 0 in the next cycle.
- R3: A host write replaces the whole addressed word and leaves every other word unchanged.
- R4: Refresh never changes stored contents. With the host idle from reset release, address a is read in cycle 2a and written back in cycle 2a+1, counting cycles from 0 after release.
- R5: `host_ready` is 1 whenever `rf_urgent` is 0 outside reset. The refresh never writes the array in a cycle in which a host request is accepted.
- R6: `rf_urgent` is 1 in a cycle when the cycles elapsed in the current pass, plus the array cycles the pass still needs, are at least `REFRESH_PERIOD`. The pass still needs two cycles per unvisited word, one fewer if the current word is waiting for its write-back. In that cycle `host_ready` is 0 and the refresh takes the array. Under back-to-back host requests with the defaults (16 words, period 64), `host_ready` is 0 in exactly cycles 32 to 63.
- R7: If the host writes the word the refresh has read but not yet written back, the write-back is dropped, the host value persists, and the refresh moves to the next address.
- R8: The address wraps from the last word to 0. `sweep_done` is 1 for exactly the cycle that completes the last word, which is cycle 31 and again cycle 63 when the host is idle with the defaults. The elapsed-time count restarts at each wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Block accepts the host request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data returned, one cycle after read acceptance |
| rf_urgent | output | 1 | Refresh is behind budget and holds the array this cycle |
| sweep_done | output | 1 | One-cycle pulse on the cycle the last word completes |

## Verification
Each internal fault shows up at the ports within a bounded time, listed here from fastest to slowest:
- Bad address or phase register: with the host idle, `sweep_done` falls away from cycles 31 and 63, so the fault appears within one pass of 32 cycles.
- Wrong budget count: `host_ready` drops in the wrong cycles under back-to-back traffic, visible within the first 64 cycles.
- Missed hazard: the stale write-back lands one idle cycle after the host write, and the next read of that word returns the old value.
- Wrong refresh data path: a later host read returns changed contents after several idle passes.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic {
    PH_READ  = 1'b0,
    PH_WBACK = 1'b1
  } rf_phase_e;
endpackage

// File: rtl/rfe_rst_sync.sv
module rfe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rfe_store.sv
module rfe_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
  import rfe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output rf_phase_e         rf_phase,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_wr,
  output logic              wrap
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q, addr_d;
  rf_phase_e         phase_q, phase_d;
  logic [DATA_W-1:0] hold_q;
  logic              hold_en;
  logic              hazard;
  logic              advance;

  always_comb begin
    hazard  = host_wr && (phase_q == PH_WBACK) && (host_addr == addr_q);
    hold_en = slot && (phase_q == PH_READ);
    rf_wr   = slot && (phase_q == PH_WBACK) && !hazard;
    advance = (phase_q == PH_WBACK) && (hazard || slot);
    wrap    = advance && (addr_q == LAST_ADDR);
    addr_d  = addr_q;
    phase_d = phase_q;
    if (hold_en) begin
      phase_d = PH_WBACK;
    end else if (advance) begin
      phase_d = PH_READ;
      addr_d  = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      phase_q <= PH_READ;
    end else begin
      addr_q  <= addr_d;
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= mem_rdata;
  end

  assign rf_addr  = addr_q;
  assign rf_phase = phase_q;
  assign rf_wdata = hold_q;

  // R4: a completed write-back moves to the next word
  a_r4_step_after_wback: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |=> (addr_q == $past(addr_q) + 1'b1) && (phase_q == PH_READ));

  // R8: the pass restarts at word zero
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (addr_q == '0) && (phase_q == PH_READ));
endmodule

// File: rtl/rfe_deadline.sv
module rfe_deadline
  import rfe_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int REFRESH_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rf_addr,
  input  rf_phase_e         rf_phase,
  input  logic              wrap,
  output logic              urgent
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(REFRESH_PERIOD + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REFRESH_PERIOD);

  logic [CNT_W-1:0] elapsed_q, elapsed_d;
  logic [31:0]      remaining;
  logic [31:0]      needed;

  always_comb begin
    remaining = 2 * (32'(DEPTH) - 32'(rf_addr));
    if (rf_phase == PH_WBACK) remaining = remaining - 32'd1;
    needed = 32'(elapsed_q) + remaining;
    urgent = (needed >= 32'(REFRESH_PERIOD));
    if (wrap)                     elapsed_d = '0;
    else if (elapsed_q != CNT_MAX) elapsed_d = elapsed_q + 1'b1;
    else                          elapsed_d = elapsed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed_q <= '0;
    else        elapsed_q <= elapsed_d;
  end

  // R6: once behind, the refresh stays in charge until the pass wraps
  a_r6_urgent_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !wrap) |=> urgent);

  // R8: a wrap always restarts the budget clear of urgency
  a_r8_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !urgent);
endmodule

// File: rtl/refresh_engine.sv
module refresh_engine
  import rfe_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8,
  parameter int REFRESH_PERIOD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              rf_urgent,
  output logic              sweep_done
);
  logic              rst_ok;
  logic              host_fire, host_wr, host_rd, slot;
  logic [ADDR_W-1:0] rf_addr;
  rf_phase_e         rf_phase;
  logic [DATA_W-1:0] rf_wdata;
  logic              rf_wr;
  logic              wrap;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              urgent;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  rfe_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ok));

  always_comb begin
    host_ready = rst_ok && !urgent;
    host_fire  = host_valid && host_ready;
    host_wr    = host_fire && host_we;
    host_rd    = host_fire && !host_we;
    slot       = rst_ok && !host_fire;
    mem_we     = host_wr || rf_wr;
    mem_addr   = host_fire ? host_addr  : rf_addr;
    mem_wdata  = host_fire ? host_wdata : rf_wdata;
  end

  rfe_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk(clk), .rst_n(rst_ok), .slot(slot), .host_wr(host_wr),
    .host_addr(host_addr), .mem_rdata(mem_rdata), .rf_addr(rf_addr),
    .rf_phase(rf_phase), .rf_wdata(rf_wdata), .rf_wr(rf_wr), .wrap(wrap)
  );

  rfe_deadline #(.ADDR_W(ADDR_W), .REFRESH_PERIOD(REFRESH_PERIOD)) u_dl (
    .clk(clk), .rst_n(rst_ok), .rf_addr(rf_addr), .rf_phase(rf_phase),
    .wrap(wrap), .urgent(urgent)
  );

  rfe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) rvalid_q <= 1'b0;
    else         rvalid_q <= host_rd;
  end

  always_ff @(posedge clk) begin
    if (host_rd) rdata_q <= mem_rdata;
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign rf_urgent   = urgent;
  assign sweep_done  = wrap;

  // R2: read data one cycle after acceptance, never after a write
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_valid && host_ready) |=> (host_rvalid == !$past(host_we)));

  // R5: host and refresh never both drive the array
  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_valid && host_ready) |-> !rf_wr);

  // R7: a host write on the held word cancels its write-back
  a_r7_drop_stale: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_wr && (rf_phase == PH_WBACK) && (host_addr == rf_addr))
      |=> (rf_phase == PH_READ) && !rf_wr);
endmodule

// File: tb/sim_refresh_engine.sv
module sim_refresh_engine;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_valid, host_we;
  logic [AW-1:0] host_addr;
  logic [DW-1:0] host_wdata;
  logic          host_ready, host_rvalid, rf_urgent, sweep_done;
  logic [DW-1:0] host_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  refresh_engine #(.ADDR_W(AW), .DATA_W(DW), .REFRESH_PERIOD(64)) u0 (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .rf_urgent(rf_urgent), .sweep_done(sweep_done)
  );

  always #10 clk = ~clk;

  // {we, addr, wdata, expected read}
  localparam logic [20:0] VEC [14] = '{
    {1'b1, 4'h0, 8'hA5, 8'h00},
    {1'b1, 4'hF, 8'h3C, 8'h00},
    {1'b0, 4'h0, 8'h00, 8'hA5},
    {1'b0, 4'hF, 8'h00, 8'h3C},
    {1'b1, 4'h3, 8'h11, 8'h00},
    {1'b1, 4'h3, 8'h22, 8'h00},
    {1'b0, 4'h3, 8'h00, 8'h22},
    {1'b1, 4'h7, 8'h80, 8'h00},
    {1'b0, 4'h7, 8'h00, 8'h80},
    {1'b0, 4'h0, 8'h00, 8'hA5},
    {1'b1, 4'h8, 8'hFF, 8'h00},
    {1'b0, 4'h8, 8'h00, 8'hFF},
    {1'b0, 4'hF, 8'h00, 8'h3C},
    {1'b0, 4'h3, 8'h00, 8'h22}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic rv, output logic [DW-1:0] rd);
    host_valid = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rv = host_rvalid; rd = host_rdata;
    host_valid = 1'b0; host_we = 1'b0;
  endtask

  // leaves the bench at sample 0: the first cycle after internal release
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic rv;
    logic [DW-1:0] rd;
    int cnt, first, dcnt, ucnt;
    rst_n = 1'b0; host_valid = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_ready == 1'b0, "R1 ready", host_ready, 0);
    chk(host_rvalid == 1'b0, "R1 rvalid", host_rvalid, 0);
    chk(rf_urgent == 1'b0, "R1 urgent", rf_urgent, 0);
    chk(sweep_done == 1'b0, "R1 sweep_done", sweep_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_ready == 1'b0, "R1 ready during sync", host_ready, 0);
    @(negedge clk);

    // vector table: R2 latency/data, R3 word isolation
    for (int i = 0; i < 14; i++) begin
      do_op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], rv, rd);
      if (VEC[i][20]) chk(rv == 1'b0, "R2 no rvalid after write", rv, 0);
      else begin
        chk(rv == 1'b1, "R2 rvalid", rv, 1);
        chk(rd == VEC[i][7:0], "R3 read data", rd, VEC[i][7:0]);
      end
    end

    // R4 contents survive several refresh passes
    repeat (300) @(negedge clk);
    do_op(1'b0, 4'h0, 8'h00, rv, rd); chk(rd == 8'hA5, "R4 keep w0", rd, 8'hA5);
    do_op(1'b0, 4'h3, 8'h00, rv, rd); chk(rd == 8'h22, "R4 keep w3", rd, 8'h22);
    do_op(1'b0, 4'h7, 8'h00, rv, rd); chk(rd == 8'h80, "R4 keep w7", rd, 8'h80);
    do_op(1'b0, 4'hF, 8'h00, rv, rd); chk(rd == 8'h3C, "R4 keep w15", rd, 8'h3C);

    // R4/R8 idle pass timing, R5 ready stays high
    do_reset();
    cnt = 0; first = -1; ucnt = 0; dcnt = 0;
    for (int s = 0; s < 64; s++) begin
      if (sweep_done) begin cnt++; if (first < 0) first = s; end
      if (rf_urgent) ucnt++;
      if (!host_ready) dcnt++;
      @(negedge clk);
    end
    chk(cnt == 2, "R8 sweep_done count idle", cnt, 2);
    chk(first == 31, "R4 first wrap cycle", first, 31);
    chk(ucnt == 0, "R6 no urgency when idle", ucnt, 0);
    chk(dcnt == 0, "R5 ready high when idle", dcnt, 0);

    // R6 back-to-back host reads: urgency window
    host_valid = 1'b1; host_we = 1'b0; host_addr = 4'h0;
    do_reset();
    cnt = 0; first = -1; dcnt = 0;
    for (int s = 0; s < 64; s++) begin
      if (!host_ready) begin cnt++; if (first < 0) first = s; end
      if (sweep_done) dcnt++;
      if (rf_urgent == host_ready) begin
        checks++; failures++;
        $display("FAIL R5 ready vs urgent at %0d: actual=%0h expected=%0h", s, host_ready, !rf_urgent);
      end
      @(negedge clk);
    end
    chk(cnt == 32, "R6 ready-low cycles", cnt, 32);
    chk(first == 32, "R6 first urgent cycle", first, 32);
    chk(dcnt == 1, "R8 one wrap in budget", dcnt, 1);
    chk(host_ready == 1'b1, "R8 budget restarts", host_ready, 1);
    host_valid = 1'b0;

    // R7 hazard: write word 3 while its write-back is pending
    for (int a = 0; a < 16; a++) do_op(1'b1, AW'(a), DW'(a * 13 + 7), rv, rd);
    do_reset();
    repeat (7) @(negedge clk);
    do_op(1'b1, 4'h3, 8'hC7, rv, rd);
    repeat (10) @(negedge clk);
    do_op(1'b0, 4'h3, 8'h00, rv, rd); chk(rd == 8'hC7, "R7 host value kept", rd, 8'hC7);
    do_op(1'b0, 4'h4, 8'h00, rv, rd); chk(rd == 8'd59, "R7 next word intact", rd, 8'd59);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule